// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a processor whose instructions are all 32 bits wide. On each enabled clock edge it looks at the fetched instruction word and the two register values named by that instruction's source fields. It then loads the next program counter. The next value comes from one of three paths: a sequential step of one word, a PC-relative conditional branch, or a jump whose target is built partly from the current PC.

Branch displacements are signed word counts taken from the low 16 bits of the instruction. Each displacement is sign-extended, multiplied by four and added to the address of the following instruction. A jump keeps the top four bits of that following address, takes the 26 low instruction bits as the word address and appends two zero bits. The stall enable freezes the counter. Synchronous reset returns it to address zero.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0x00000000 on that edge.
- R2: When `adv_en` is low and `rst` is low, `pc` keeps its value across the edge, whatever the instruction and operands are.
- R3: When `adv_en` is high and the opcode (`instr[31:26]`) is anything other than 2, 4 or 5 (opcode 0 included), `pc` becomes `pc + 4`.
- R4: Opcode 4 with `rs_val == rt_val` loads `pc + 4 + (sext(instr[15:0]) << 2)`.
- R5: Opcode 4 with `rs_val != rt_val` loads `pc + 4`.
- R6: Opcode 5 with `rs_val != rt_val` loads `pc + 4 + (sext(instr[15:0]) << 2)`.
- R7: Opcode 5 with `rs_val == rt_val` loads `pc + 4`.
- R8: The 16-bit branch displacement is two's complement, so values 0x8000 to 0xFFFF move the PC backward, and the sum wraps modulo 2^32.
- R9: Opcode 2 loads `{pc_plus4[31:28], instr[25:0], 2'b00}`, where `pc_plus4` is the current PC plus 4.
- R10: Outside reset, the two low bits of `pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | PC update enable; low means stall |
| instr | input | 32 | Fetched instruction word |
| rs_val | input | 32 | Value of the register named by bits 25:21 |
| rt_val | input | 32 | Value of the register named by bits 20:16 |
| pc | output | 32 | Current program counter |

## Verification
Each result lands on `pc` at the first rising edge after the inputs are applied. There is exactly one register between the inputs and the output. The bench changes its inputs one time unit after an edge and compares `pc` one time unit after the following edge, against a next-address model in the bench. The sweep covers every opcode from 0 to 7 and both operand relations, with displacements at zero, at the positive and negative extremes, and at minus one. A backward wrap puts the PC's upper nibble at 0xF before the jumps are checked.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter logic [5:0]  OP_JUMP  = 6'd2,
  parameter logic [5:0]  OP_BREQ  = 6'd4,
  parameter logic [5:0]  OP_BRNE  = 6'd5,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv_en,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc
);

  logic [5:0]  opc;
  logic [31:0] seq_pc, disp, br_tgt, jmp_tgt, nxt;
  logic        same, take_br;

  assign opc     = instr[31:26];
  assign same    = (rs_val == rt_val);
  assign seq_pc  = pc + 32'd4;
  assign disp    = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign br_tgt  = seq_pc + disp;
  assign jmp_tgt = {seq_pc[31:28], instr[25:0], 2'b00};
  assign take_br = ((opc == OP_BREQ) && same) || ((opc == OP_BRNE) && !same);

  always_comb begin
    if (opc == OP_JUMP)  nxt = jmp_tgt;
    else if (take_br)    nxt = br_tgt;
    else                 nxt = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst)         pc <= RESET_PC;
    else if (adv_en) pc <= nxt;
  end

  // R1
  reset_load_chk: assert property (@(posedge clk) rst |=> pc == RESET_PC);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && opc != OP_JUMP && opc != OP_BREQ && opc != OP_BRNE)
    |=> pc == $past(pc) + 32'd4);

  // R5
  breq_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && opc == OP_BREQ && rs_val != rt_val) |=> pc == $past(pc) + 32'd4);

  // R7
  brne_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && opc == OP_BRNE && rs_val == rt_val) |=> pc == $past(pc) + 32'd4);

  // R9
  jump_field_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && opc == OP_JUMP) |=> pc[27:2] == $past(instr[25:0]));

  // R10
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc[1:0] == 2'b00);

endmodule

// File: tb/tb_next_pc_unit.sv
module tb_next_pc_unit;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        adv_en = 0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] pc;
  logic [31:0] exp_pc;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  next_pc_unit dut (.clk(clk), .rst(rst), .adv_en(adv_en), .instr(instr),
                    .rs_val(rs_val), .rt_val(rt_val), .pc(pc));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] p, input logic [31:0] w,
                                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] nx4;
    nx4 = p + 32'd4;
    case (w[31:26])
      6'd2: return {nx4[31:28], w[25:0], 2'b00};
      6'd4: return (a == b) ? nx4 + {{14{w[15]}}, w[15:0], 2'b00} : nx4;
      6'd5: return (a != b) ? nx4 + {{14{w[15]}}, w[15:0], 2'b00} : nx4;
      default: return nx4;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: pc actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic step(input logic en, input logic [31:0] w, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    adv_en = en; instr = w; rs_val = a; rt_val = b;
    exp_pc = en ? model(exp_pc, w, a, b) : exp_pc;
    @(posedge clk); #1;
    check(tag, pc, exp_pc);
    check("R10", {30'd0, pc[1:0]}, 32'd0);
  endtask

  function automatic logic [15:0] imm_pick(input int k);
    case (k)
      0: return 16'd3;
      1: return 16'hFFFF;
      2: return 16'h7FFF;
      3: return 16'h8000;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    @(posedge clk); #1;
    @(posedge clk); #1;
    exp_pc = 32'h0;
    check("R1", pc, 32'h0);
    rst = 0;

    // R4: example word, rs==rt, three words ahead of pc+4
    step(1, 32'h1120_0003, 32'd7, 32'd7, "R4");
    check("R4", pc, 32'h0000_0010);
    // R5: same word, operands differ
    step(1, 32'h1120_0003, 32'd7, 32'd8, "R5");
    // R2: stalled jump has no effect
    step(0, 32'h0BFF_FFFF, 32'd1, 32'd1, "R2");
    step(0, 32'h1000_8000, 32'd1, 32'd1, "R2");

    // R8: backward wrap to upper nibble F
    step(1, {6'd4, 10'd0, 16'hFFF0}, 32'd0, 32'd0, "R8");
    check("R8", pc[31:28] == 4'hF ? 32'd1 : 32'd0, 32'd1);
    // R9: jump keeps upper nibble F
    step(1, {6'd2, 26'h0000_123}, 32'd0, 32'd0, "R9");
    check("R9", pc, 32'hF000_048C);

    for (int op = 0; op < 8; op++)
      for (int eq = 0; eq < 2; eq++)
        for (int k = 0; k < 5; k++) begin
          logic [15:0] im;
          string tg;
          im = imm_pick(k);
          if (op == 4) tg = eq ? (im[15] ? "R8" : "R4") : "R5";
          else if (op == 5) tg = !eq ? (im[15] ? "R8" : "R6") : "R7";
          else if (op == 2) tg = "R9";
          else tg = "R3";
          step(1, {op[5:0], 5'd9, 5'd10, im}, 32'hA5A5_0000 + k,
               eq ? 32'hA5A5_0000 + k : 32'h5A5A_0000, tg);
          if (k == 2) step(0, {6'd2, 26'h2AA_AAAA}, 32'd0, 32'd0, "R2");
        end

    rst = 1;
    @(posedge clk); #1;
    exp_pc = 32'h0;
    check("R1", pc, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule